// File: doc/BRIEF.md
# Thermal Restart Re-Arm Supervisor

This block decides whether the processor gets a fresh start after a temperature excursion. Two comparator outputs feed it. One says the die is outside the re-arm band. The other says the die has come back inside the reset band. Both inputs are synchronised to the local clock before any logic uses them.

Software accesses an 8-bit control/trim register over a simple write port. A 3-bit restart-high threshold code sits in bits 6:4. Bit 7 and bits 3:1 hold factory trim: they load from a parameter at reset and bus writes cannot change them. Bit 0 is a read-only flag that shows the synchronised out-of-band state.

A separate write strobe sets or clears the restart enable. A set only takes effect while the out-of-band flag is high. Once armed, the block waits for the temperature to return inside the reset band. It then sends a single-clock restart pulse to the reset logic and disarms itself.

Top module: `thermal_rearm_ctrl`

## Requirements
- R1: A cycle with `reg_wr_i` high loads `reg_wdata_i[6:4]` into the threshold field, bits 6:4 of `reg_rdata_o`, and the new value shows from the next clock. Every code from 0 to 7 is accepted, 6 included.
- R2: After reset, the threshold field reads 0, bit 7 and bits 3:1 read the matching bits of `TRIM_INIT`, `armed_o` reads 0 and `restart_o` reads 0.
- R3: Bus writes never change `reg_rdata_o` bit 7 or bits 3:1. Those bits keep their reset values for any write data.
- R4: `reg_rdata_o` bit 0 equals `temp_out_band_i` delayed by the `SYNC_STAGES` clock edges of its synchronizer (2 by default). Bus writes cannot change it.
- R5: An arm write (`arm_wr_i` high, `arm_wdata_i` 1) while bit 0 reads 0 is ignored, and `armed_o` stays 0.
- R6: An arm write with `arm_wdata_i` 1 while bit 0 reads 1 sets `armed_o` from the next clock. An arm write with `arm_wdata_i` 0 clears it.
- R7: While `armed_o` is 1, the synchronised in-band indication raises `restart_o` for exactly one clock. With the default settings, that clock comes three edges after `temp_in_band_i` rises.
- R8: The clock edge that raises `restart_o` also clears `armed_o`. No further pulse follows while the in-band indication stays high.
- R9: When the block is not armed, the in-band indication never produces a restart pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| temp_out_band_i | input | 1 | Comparator: temperature outside the re-arm band (asynchronous) |
| temp_in_band_i | input | 1 | Comparator: temperature inside the reset band (asynchronous) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data; only bits 6:4 are used |
| arm_wr_i | input | 1 | Restart-enable write strobe |
| arm_wdata_i | input | 1 | Requested restart-enable value |
| reg_rdata_o | output | 8 | Register read-back |
| armed_o | output | 1 | Restart enable status |
| restart_o | output | 1 | One-clock processor restart request |

## Verification
- **Corrupted trim bits.** They show at the port in the first read-back after the offending write.
- **Wrong threshold capture.** It shows one clock after the write. Sweeping all 256 write-data values exposes any swapped or dropped bit.
- **Arm accepted without the out-of-band flag.** `armed_o` shows it one clock later. A missed disarm shows as a second restart pulse three clocks after the next in-band rise.
- **Wrong synchronizer depth.** It moves both the bit-0 flag and the restart pulse by whole clocks. The bench samples these at exact cycle positions.

// File: rtl/trr_pkg.sv
package trr_pkg;
   localparam int REG_W   = 8;
   localparam int THR_LSB = 4;
   localparam int THR_W   = 3;
   localparam logic [REG_W-1:0] TRIM_MASK = 8'b1000_1110;
   localparam logic [REG_W-1:0] THR_MASK  = 8'b0111_0000;

   typedef struct packed {
      logic out_band;
      logic in_band;
   } temp_sync_t;
endpackage

// File: rtl/trr_sync.sv
module trr_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   if (STAGES < 2) begin : g_bad_depth
      $error("trr_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) chain_q[s] <= '0;
         else if (s == 0) chain_q[s] <= async_i;
         else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
   end

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/trr_regfile.sv
module trr_regfile
   import trr_pkg::*;
#(
   parameter logic [REG_W-1:0] TRIM_INIT = 8'h00
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_i,
   input  logic [REG_W-1:0] wdata_i,
   input  logic             out_band_s_i,
   output logic [REG_W-1:0] rdata_o
);
   logic [THR_W-1:0] thr_q;
   logic [REG_W-1:0] trim_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         thr_q  <= '0;
         trim_q <= TRIM_INIT & TRIM_MASK;
      end else if (wr_i) begin
         thr_q  <= wdata_i[THR_LSB +: THR_W];
      end
   end

   always_comb begin
      rdata_o = trim_q;
      rdata_o[THR_LSB +: THR_W] = thr_q;
      rdata_o[0] = out_band_s_i;
   end

   AST_THR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i |=> rdata_o[THR_LSB +: THR_W] == $past(wdata_i[THR_LSB +: THR_W])); // R1
   AST_TRIM_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $stable(rdata_o & TRIM_MASK)); // R3
endmodule

// File: rtl/trr_arm.sv
module trr_arm (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic arm_wr_i,
   input  logic arm_wdata_i,
   input  logic out_band_s_i,
   input  logic in_band_s_i,
   output logic armed_o,
   output logic restart_o
);
   logic arm_q, restart_q, fire;

   assign fire = arm_q & in_band_s_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         arm_q     <= 1'b0;
         restart_q <= 1'b0;
      end else begin
         restart_q <= fire;
         if (fire)          arm_q <= 1'b0;
         else if (arm_wr_i) arm_q <= arm_wdata_i & out_band_s_i;
      end
   end

   assign armed_o   = arm_q;
   assign restart_o = restart_q;

   AST_NO_ARM_INSIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!arm_q && !out_band_s_i) |=> !arm_q); // R5
   AST_PULSE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      restart_q |=> !restart_q); // R7
   AST_DISARM_ON_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      restart_q |-> !arm_q); // R8
   AST_NO_UNARMED_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!arm_q) |=> !restart_q); // R9
endmodule

// File: rtl/thermal_rearm_ctrl.sv
module thermal_rearm_ctrl
   import trr_pkg::*;
#(
   parameter int               SYNC_STAGES = 2,
   parameter logic [REG_W-1:0] TRIM_INIT   = 8'hA6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             temp_out_band_i,
   input  logic             temp_in_band_i,
   input  logic             reg_wr_i,
   input  logic [REG_W-1:0] reg_wdata_i,
   input  logic             arm_wr_i,
   input  logic             arm_wdata_i,
   output logic [REG_W-1:0] reg_rdata_o,
   output logic             armed_o,
   output logic             restart_o
);
   localparam int NSIG = $bits(temp_sync_t);

   temp_sync_t t_async, t_sync;

   assign t_async.out_band = temp_out_band_i;
   assign t_async.in_band  = temp_in_band_i;

   trr_sync #(.STAGES(SYNC_STAGES), .WIDTH(NSIG)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .async_i(t_async),
      .sync_o (t_sync)
   );

   trr_regfile #(.TRIM_INIT(TRIM_INIT)) u_regs (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_i        (reg_wr_i),
      .wdata_i     (reg_wdata_i),
      .out_band_s_i(t_sync.out_band),
      .rdata_o     (reg_rdata_o)
   );

   trr_arm u_arm (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .arm_wr_i    (arm_wr_i),
      .arm_wdata_i (arm_wdata_i),
      .out_band_s_i(t_sync.out_band),
      .in_band_s_i (t_sync.in_band),
      .armed_o     (armed_o),
      .restart_o   (restart_o)
   );

   AST_ARM_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(armed_o) |-> $past(reg_rdata_o[0])); // R6
endmodule

// File: tb/test_thermal_rearm_ctrl.sv
module test_thermal_rearm_ctrl;
   localparam logic [7:0] TRIM = 8'hA6;
   logic clk = 0, rst_n = 0;
   logic out_b = 0, in_b = 0, wr = 0, awr = 0, ad = 0;
   logic [7:0] wd = 0;
   logic [7:0] rd;
   logic armed, rst_pulse;
   int checks = 0, fails = 0, pulses = 0;

   always #2 clk = ~clk;

   thermal_rearm_ctrl #(.SYNC_STAGES(2), .TRIM_INIT(TRIM)) i_thermal_rearm_ctrl (
      .clk_i(clk), .rst_ni(rst_n), .temp_out_band_i(out_b), .temp_in_band_i(in_b),
      .reg_wr_i(wr), .reg_wdata_i(wd), .arm_wr_i(awr), .arm_wdata_i(ad),
      .reg_rdata_o(rd), .armed_o(armed), .restart_o(rst_pulse));

   always @(negedge clk) if (rst_n && rst_pulse) pulses++;

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic arm_write(input logic v);
      @(negedge clk); awr = 1; ad = v;
      @(negedge clk); awr = 0; ad = 0;
   endtask

   initial begin
      #200000;
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      ticks(2);
      // R2 reset state
      chk("R2 reg", rd, TRIM & 8'h8E);
      chk("R2 armed", {7'd0, armed}, 0);
      chk("R2 restart", {7'd0, rst_pulse}, 0);
      rst_n = 1;
      ticks(2);
      // R1 R3 R4: sweep all write data with flag low and high
      for (int f = 0; f < 2; f++) begin
         out_b = f[0];
         ticks(3);
         for (int d = 0; d < 256; d++) begin
            wr = 1; wd = d[7:0];
            @(negedge clk); wr = 0;
            chk("R1 threshold", {5'd0, rd[6:4]}, {5'd0, d[6:4]});
            chk("R3 trim", rd & 8'h8E, TRIM & 8'h8E);
            chk("R4 flag", {7'd0, rd[0]}, {7'd0, f[0]});
         end
      end
      // R1 wakeup value 6
      wr = 1; wd = 8'h60; @(negedge clk); wr = 0;
      chk("R1 code6", rd, (TRIM & 8'h8E) | 8'h60 | 8'h01);
      // R4 latency: falls, visible only after two edges
      out_b = 0;
      @(negedge clk); chk("R4 not yet", {7'd0, rd[0]}, 1);
      @(negedge clk); chk("R4 latency", {7'd0, rd[0]}, 0);
      // R5 arm ignored while inside
      arm_write(1);
      chk("R5 ignored", {7'd0, armed}, 0);
      // R9 in-band without arm
      in_b = 1; ticks(6);
      chk("R9 no pulse", pulses[7:0], 0);
      in_b = 0; ticks(3);
      // R6 arm and disarm
      out_b = 1; ticks(3);
      arm_write(1);
      chk("R6 armed", {7'd0, armed}, 1);
      arm_write(0);
      chk("R6 cleared", {7'd0, armed}, 0);
      arm_write(1);
      chk("R6 rearmed", {7'd0, armed}, 1);
      // R7 timing of pulse
      out_b = 0; in_b = 1;
      @(negedge clk); chk("R7 edge1", {7'd0, rst_pulse}, 0);
      @(negedge clk); chk("R7 edge2", {7'd0, rst_pulse}, 0);
      @(negedge clk); chk("R7 edge3 pulse", {7'd0, rst_pulse}, 1);
      chk("R8 disarmed", {7'd0, armed}, 0);
      @(negedge clk); chk("R7 one cycle", {7'd0, rst_pulse}, 0);
      ticks(10);
      chk("R8 single pulse", pulses[7:0], 1);
      // R5: arm attempt while in-band and not out-of-band
      arm_write(1);
      ticks(5);
      chk("R5 no rearm", {7'd0, armed}, 0);
      chk("R9 still one", pulses[7:0], 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule